// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block carries out the data movement for one channel of a DMA controller once an arbiter has granted that channel. A start pulse loads a job: a source address, a destination address, a 24-bit transfer count, a unit size and the options. The sequencer then drives a request/ready memory port until the count runs out. In dual-address mode every transfer is a read from the source followed by a write of the same data to the destination. In single-address mode every transfer is one read access at the source address, and an acknowledge line tells the external device to take the data from the bus.

Two options change how the source side behaves. With reload enabled, the source address returns to its programmed start after every fourth transfer, so a short source region can be replayed. With indirect addressing enabled, the source register holds the address of a 32-bit pointer. Each transfer then fetches that pointer first and reads the data from the address it holds. When the last transfer completes, a sticky completion flag is set. While interrupts are enabled, an interrupt line follows that flag.

The state machine has five states. IDLE waits for start. PTR fetches the indirect pointer. READ reads the source data. WRITE writes the destination. SINGLE performs the acknowledged single-address access. The transitions are:
- IDLE to SINGLE, PTR or READ on start, according to the mode.
- PTR to READ on ready.
- READ to WRITE on ready.
- WRITE to PTR or READ on ready while transfers remain, or to IDLE on ready for the last transfer.
- SINGLE to itself on ready while transfers remain, or to IDLE on ready for the last transfer.

Top module: `dma_xfer_seq`

## Requirements
- R1: In dual-address mode each transfer is a read (mem_we=0) at the data address followed by a write (mem_we=1) at the destination address, and the write data equals the data returned by that read.
- R2: In single-address mode each transfer is exactly one read access at the source address with dev_ack high during it. No write is issued and the destination address is neither used nor stepped.
- R3: mem_size reports the unit as 0=byte, 1=16-bit word, 2=32-bit longword, and the address step is 1, 2 or 4 bytes to match. A unit code of 3 behaves as longword.
- R4: Source and destination each select their address mode independently, encoded 0=fixed, 1=increment, 2=decrement, 3=fixed. The address moves by one step after each completed transfer.
- R5: xfer_left is loaded from cfg_count on start and drops by one per completed transfer. A loaded value of 0 means 2^24 transfers, so the first transfer leaves 24'hFFFFFF and the job continues.
- R6: After the programmed number of transfers the sequencer returns to idle (busy low), sets done_flag, and drives irq equal to done_flag AND irq_en.
- R7: done_flag stays set until a flag_clr pulse clears it. If completion and flag_clr fall in the same cycle, the flag ends up set.
- R8: With reload enabled, the source address returns to its start value after every fourth transfer instead of stepping.
- R9: With indirect addressing in dual mode, each transfer first performs a 32-bit read (mem_size=2) at the source register. The returned word is used as the data read address, and the write follows. The source register steps by 4 per transfer under its mode. Indirect is ignored in single mode.
- R10: A raised mem_req keeps its address, direction and size unchanged until mem_ready is seen. An access completes in the cycle where mem_req and mem_ready are both high.
- R11: A start pulse while busy is ignored. The running job, its addresses and its count are unaffected.
- R12: After reset the sequencer is idle, with mem_req, dev_ack, done_flag and irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Grant pulse that loads and launches a job when idle |
| cfg_src | input | 32 | Start source address (pointer address in indirect mode) |
| cfg_dst | input | 32 | Start destination address |
| cfg_count | input | 24 | Transfer count, 0 means 2^24 |
| cfg_unit | input | 2 | Unit size code |
| cfg_src_mode | input | 2 | Source address mode |
| cfg_dst_mode | input | 2 | Destination address mode |
| cfg_single | input | 1 | 1 selects single-address mode |
| cfg_reload | input | 1 | Enables source reload every fourth transfer |
| cfg_indirect | input | 1 | Enables indirect source addressing |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the completion flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Access address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| dev_ack | output | 1 | External device acknowledge during single-address access |
| busy | output | 1 | A job is running |
| xfer_left | output | 24 | Transfers remaining |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Completion interrupt |

## Verification
The completion flag can be set by the final transfer in the same clock in which software pulses flag_clr. The bench provokes this by raising flag_clr at the same falling edge where its memory model grants ready to the last access of a job. It then judges the result from done_flag and irq after the edge: both must read set, and only a later separate clear may drop them. The same model also grants ready after random wait states and pulses start in the middle of a running job, so stalls and ignored starts are covered.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        UNIT_BYTE = 2'd0,
        UNIT_WORD = 2'd1,
        UNIT_LONG = 2'd2,
        UNIT_RSVD = 2'd3
    } unit_e;

    typedef enum logic [1:0] {
        AM_FIXED = 2'd0,
        AM_INC   = 2'd1,
        AM_DEC   = 2'd2,
        AM_HOLD  = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR,
        ST_READ,
        ST_WRITE,
        ST_SINGLE
    } seq_state_e;

    // Byte step for one unit; the reserved code behaves as longword.
    function automatic logic [2:0] unit_bytes(unit_e u);
        logic [2:0] b;
        unique case (u)
            UNIT_BYTE: b = 3'd1;
            UNIT_WORD: b = 3'd2;
            default:   b = 3'd4;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dma_addr_reg.sv
module dma_addr_reg
    import dma_seq_pkg::*;
#(
    parameter int AW            = 32,
    parameter bit HAS_RELOAD    = 1'b0,
    parameter int RELOAD_PERIOD = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step_en,
    input  amode_e        mode,
    input  logic [2:0]    step_amt,
    input  logic          reload_en,
    output logic [AW-1:0] addr_q
);

    localparam int RW = (RELOAD_PERIOD > 1) ? $clog2(RELOAD_PERIOD) : 1;

    logic [AW-1:0] stepped;

    always_comb begin
        unique case (mode)
            AM_INC:  stepped = addr_q + AW'(step_amt);
            AM_DEC:  stepped = addr_q - AW'(step_amt);
            default: stepped = addr_q;
        endcase
    end

    generate
        if (HAS_RELOAD) begin : g_reload
            logic [AW-1:0] base_q;
            logic [RW-1:0] phase_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    addr_q  <= '0;
                    base_q  <= '0;
                    phase_q <= '0;
                end else if (load) begin
                    addr_q  <= load_val;
                    base_q  <= load_val;
                    phase_q <= '0;
                end else if (step_en) begin
                    if (reload_en && (phase_q == RW'(RELOAD_PERIOD - 1))) begin
                        addr_q  <= base_q;
                        phase_q <= '0;
                    end else begin
                        addr_q <= stepped;
                        if (reload_en) begin
                            phase_q <= phase_q + 1'b1;
                        end
                    end
                end
            end
        end else begin : g_plain
            logic unused_reload;
            assign unused_reload = reload_en;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    addr_q <= '0;
                end else if (load) begin
                    addr_q <= load_val;
                end else if (step_en) begin
                    addr_q <= stepped;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec_en,
    output logic [CW-1:0] count_q,
    output logic          last
);

    // A loaded zero wraps on the first decrement, giving 2^CW transfers.
    assign last = (count_q == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (dec_en) begin
            count_q <= count_q - 1'b1;
        end
    end

endmodule

// File: rtl/dma_done_flag.sv
module dma_done_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag_q
);

    // Setting wins over a coincident clear so that no completion is lost.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_seq_pkg::*;
#(
    parameter int AW            = 32,
    parameter int DW            = 32,
    parameter int CW            = 24,
    parameter int RELOAD_PERIOD = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_count,
    input  logic [1:0]    cfg_unit,
    input  logic [1:0]    cfg_src_mode,
    input  logic [1:0]    cfg_dst_mode,
    input  logic          cfg_single,
    input  logic          cfg_reload,
    input  logic          cfg_indirect,
    input  logic          irq_en,
    input  logic          flag_clr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          dev_ack,
    output logic          busy,
    output logic [CW-1:0] xfer_left,
    output logic          done_flag,
    output logic          irq
);

    localparam logic [2:0] PTR_STEP = 3'd4;

    seq_state_e state_q, state_d;

    unit_e         unit_q;
    amode_e        src_mode_q, dst_mode_q;
    logic          single_q, reload_q, ind_q;
    logic [AW-1:0] ptr_q;
    logic [DW-1:0] data_q;
    logic [AW-1:0] src_addr, dst_addr;
    logic [2:0]    src_step;
    logic          launch, xfer_end, last;

    assign launch   = (state_q == ST_IDLE) && start;
    assign xfer_end = mem_ready && ((state_q == ST_WRITE) || (state_q == ST_SINGLE));
    assign src_step = ind_q ? PTR_STEP : unit_bytes(unit_q);
    assign busy     = (state_q != ST_IDLE);
    assign irq      = done_flag & irq_en;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (cfg_single)        state_d = ST_SINGLE;
                    else if (cfg_indirect) state_d = ST_PTR;
                    else                   state_d = ST_READ;
                end
            end
            ST_PTR: begin
                if (mem_ready) state_d = ST_READ;
            end
            ST_READ: begin
                if (mem_ready) state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (mem_ready) begin
                    if (last)       state_d = ST_IDLE;
                    else if (ind_q) state_d = ST_PTR;
                    else            state_d = ST_READ;
                end
            end
            ST_SINGLE: begin
                if (mem_ready) state_d = last ? ST_IDLE : ST_SINGLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_size  = unit_q;
        mem_wdata = '0;
        dev_ack   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_PTR: begin
                mem_req  = 1'b1;
                mem_addr = src_addr;
                mem_size = UNIT_LONG;
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = ind_q ? ptr_q : src_addr;
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_addr;
                mem_wdata = data_q;
            end
            ST_SINGLE: begin
                mem_req  = 1'b1;
                mem_addr = src_addr;
                dev_ack  = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // Job configuration captured at launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unit_q     <= UNIT_BYTE;
            src_mode_q <= AM_FIXED;
            dst_mode_q <= AM_FIXED;
            single_q   <= 1'b0;
            reload_q   <= 1'b0;
            ind_q      <= 1'b0;
        end else if (launch) begin
            unit_q     <= (cfg_unit == 2'd3) ? UNIT_LONG : unit_e'(cfg_unit);
            src_mode_q <= amode_e'(cfg_src_mode);
            dst_mode_q <= amode_e'(cfg_dst_mode);
            single_q   <= cfg_single;
            reload_q   <= cfg_reload;
            ind_q      <= cfg_indirect & ~cfg_single;
        end
    end

    // Pointer and data holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            data_q <= '0;
        end else begin
            if ((state_q == ST_PTR) && mem_ready) begin
                ptr_q <= mem_rdata[AW-1:0];
            end
            if ((state_q == ST_READ) && mem_ready) begin
                data_q <= mem_rdata;
            end
        end
    end

    dma_addr_reg #(
        .AW(AW), .HAS_RELOAD(1'b1), .RELOAD_PERIOD(RELOAD_PERIOD)
    ) u_src (
        .clk(clk), .rst_n(rst_n), .load(launch), .load_val(cfg_src),
        .step_en(xfer_end), .mode(src_mode_q), .step_amt(src_step),
        .reload_en(reload_q), .addr_q(src_addr)
    );

    dma_addr_reg #(
        .AW(AW), .HAS_RELOAD(1'b0), .RELOAD_PERIOD(RELOAD_PERIOD)
    ) u_dst (
        .clk(clk), .rst_n(rst_n), .load(launch), .load_val(cfg_dst),
        .step_en(xfer_end & ~single_q), .mode(dst_mode_q),
        .step_amt(unit_bytes(unit_q)), .reload_en(1'b0), .addr_q(dst_addr)
    );

    dma_xfer_count #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(launch), .load_val(cfg_count),
        .dec_en(xfer_end), .count_q(xfer_left), .last(last)
    );

    dma_done_flag u_done (
        .clk(clk), .rst_n(rst_n), .set(xfer_end & last), .clr(flag_clr),
        .flag_q(done_flag)
    );

endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          flag_clr,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    mem_size,
    input logic          mem_ready,
    input logic          dev_ack,
    input logic          busy,
    input logic [CW-1:0] xfer_left,
    input logic          done_flag
);

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size));

    p_ack_is_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> mem_req && !mem_we);

    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready && (mem_we || dev_ack) |=> xfer_left == $past(xfer_left) - 1'b1);

    p_done_on_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag && !flag_clr |=> done_flag);

    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !(mem_req && mem_ready && (mem_we || dev_ack)) |=> xfer_left == $past(xfer_left));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !dev_ack);

endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .flag_clr(flag_clr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_ready(mem_ready), .dev_ack(dev_ack), .busy(busy), .xfer_left(xfer_left),
    .done_flag(done_flag)
);

// File: tb/test_dma_xfer_seq.sv
module test_dma_xfer_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_src = '0, cfg_dst = '0;
    logic [23:0] cfg_count = '0;
    logic [1:0]  cfg_unit = '0, cfg_src_mode = '0, cfg_dst_mode = '0;
    logic        cfg_single = 1'b0, cfg_reload = 1'b0, cfg_indirect = 1'b0;
    logic        irq_en = 1'b0, flag_clr = 1'b0;
    logic        mem_req, mem_we, dev_ack, busy, done_flag, irq;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  mem_size;
    logic        mem_ready = 1'b0;
    logic [23:0] xfer_left;

    always #10 clk = ~clk;

    dma_xfer_seq i_dma_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_count(cfg_count), .cfg_unit(cfg_unit), .cfg_src_mode(cfg_src_mode),
        .cfg_dst_mode(cfg_dst_mode), .cfg_single(cfg_single), .cfg_reload(cfg_reload),
        .cfg_indirect(cfg_indirect), .irq_en(irq_en), .flag_clr(flag_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .dev_ack(dev_ack), .busy(busy), .xfer_left(xfer_left), .done_flag(done_flag), .irq(irq)
    );

    int vectors = 0, miscompares = 0, cycles = 0;
    bit finished = 0;

    // Reference model state
    logic [31:0] m_src, m_base, m_dst, m_ptr, m_data, wait_addr;
    int          m_left, m_rc, m_phase;
    logic [1:0]  c_unit, c_sm, c_dm;
    bit          c_single, c_reload, c_ind, coinc_arm, coinc_set, was_wait;
    string       cur_tag = "R1";

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fmem(logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[31:16] ^ 16'h0F0F};
    endfunction

    function automatic logic [1:0] exp_size(logic [1:0] u);
        return (u == 2'd3) ? 2'd2 : u;
    endfunction

    function automatic int unit_step(logic [1:0] u);
        return (u == 2'd0) ? 1 : ((u == 2'd1) ? 2 : 4);
    endfunction

    function automatic logic [31:0] mstep(logic [31:0] a, logic [1:0] m, int amt);
        if (m == 2'd1) return a + amt;
        if (m == 2'd2) return a - amt;
        return a;
    endfunction

    task automatic model_access();
        logic [31:0] ea;
        logic [3:0]  ectl;
        bit          is_end;
        is_end = 0;
        if (c_single) begin
            ea = m_src; ectl = {1'b0, 1'b1, exp_size(c_unit)}; is_end = 1;
        end else if (m_phase == 0) begin
            ea = m_src; ectl = {1'b0, 1'b0, 2'd2};
        end else if (m_phase == 1) begin
            ea = c_ind ? m_ptr : m_src; ectl = {1'b0, 1'b0, exp_size(c_unit)};
        end else begin
            ea = m_dst; ectl = {1'b1, 1'b0, exp_size(c_unit)}; is_end = 1;
        end
        chk(mem_addr == ea, cur_tag, mem_addr, ea);
        chk({mem_we, dev_ack, mem_size} == ectl, "R3", 32'({mem_we, dev_ack, mem_size}), 32'(ectl));
        if (!c_single && m_phase == 2) chk(mem_wdata == m_data, "R1", mem_wdata, m_data);
        mem_rdata = fmem(ea);
        if (!c_single && m_phase == 0) begin
            m_ptr = fmem(ea); m_phase = 1;
        end else if (!c_single && m_phase == 1) begin
            m_data = fmem(ea); m_phase = 2;
        end
        if (is_end) begin
            if (coinc_arm && m_left == 1) begin
                flag_clr = 1'b1; coinc_set = 1; coinc_arm = 0;
            end
            m_left--;
            if (c_reload) begin
                m_rc++;
                if (m_rc == 4) begin m_src = m_base; m_rc = 0; end
                else m_src = mstep(m_src, c_sm, c_ind ? 4 : unit_step(c_unit));
            end else begin
                m_src = mstep(m_src, c_sm, c_ind ? 4 : unit_step(c_unit));
            end
            if (!c_single) m_dst = mstep(m_dst, c_dm, unit_step(c_unit));
            m_phase = c_ind ? 0 : 1;
        end
    endtask

    // Memory responder with random wait states
    always @(negedge clk) begin
        if (coinc_set) begin flag_clr = 1'b0; coinc_set = 0; end
        mem_ready = 1'b0;
        if (rst_n && mem_req) begin
            if (was_wait) chk(mem_addr == wait_addr, "R10", mem_addr, wait_addr);
            if (($urandom % 3) != 0) begin
                model_access();
                mem_ready = 1'b1;
                was_wait = 0;
            end else begin
                was_wait = 1;
                wait_addr = mem_addr;
            end
        end else begin
            was_wait = 0;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    task automatic launch(input string tag, input logic [31:0] s, input logic [31:0] d,
                          input logic [23:0] n, input logic [1:0] u, input logic [1:0] sm,
                          input logic [1:0] dm, input bit sg, input bit rl, input bit ind,
                          input bit ien, input bit coinc);
        @(negedge clk);
        m_src = s; m_base = s; m_dst = d; m_rc = 0;
        m_left = (n == 0) ? (1 << 24) : int'(n);
        c_unit = u; c_sm = sm; c_dm = dm; c_single = sg; c_reload = rl; c_ind = ind && !sg;
        m_phase = c_ind ? 0 : 1; cur_tag = tag; coinc_arm = coinc;
        cfg_src = s; cfg_dst = d; cfg_count = n; cfg_unit = u; cfg_src_mode = sm;
        cfg_dst_mode = dm; cfg_single = sg; cfg_reload = rl; cfg_indirect = ind; irq_en = ien;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R6", 32'(busy), 32'd1);
        chk(xfer_left == n, "R5", 32'(xfer_left), 32'(n));
    endtask

    task automatic run_job(input string tag, input logic [31:0] s, input logic [31:0] d,
                           input logic [23:0] n, input logic [1:0] u, input logic [1:0] sm,
                           input logic [1:0] dm, input bit sg, input bit rl, input bit ind,
                           input bit ien, input bit disturb, input bit coinc);
        launch(tag, s, d, n, u, sm, dm, sg, rl, ind, ien, coinc);
        if (disturb) begin
            repeat (2) @(negedge clk);
            cfg_src = ~s; cfg_dst = ~d; cfg_count = 24'd1; cfg_single = ~sg;
            cfg_src_mode = ~sm; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R11", 32'(busy), 32'd1);
        end
        while (busy) @(negedge clk);
        chk(m_left == 0, "R6", 32'(m_left), 32'd0);
        chk(done_flag == 1'b1, coinc ? "R7" : "R6", 32'(done_flag), 32'd1);
        chk(irq == ien, "R6", 32'(irq), 32'(ien));
        chk(xfer_left == 24'd0, "R5", 32'(xfer_left), 32'd0);
        repeat (2) @(negedge clk);
        chk(done_flag == 1'b1, "R7", 32'(done_flag), 32'd1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk({done_flag, irq} == 2'b00, "R7", 32'({done_flag, irq}), 32'd0);
    endtask

    task automatic check_reset_state();
        chk({busy, mem_req, dev_ack, done_flag, irq} == 5'b0, "R12",
            32'({busy, mem_req, dev_ack, done_flag, irq}), 32'd0);
    endtask

    initial begin
        string tg;
        bit sg, rl, ind;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();

        // Directed corner cases
        run_job("R1", 32'h0000_1000, 32'h0000_2000, 24'd3, 2'd0, 2'd1, 2'd1, 0, 0, 0, 1, 0, 0);
        run_job("R4", 32'h0000_3000, 32'h0000_4000, 24'd4, 2'd2, 2'd2, 2'd0, 0, 0, 0, 1, 0, 0);
        run_job("R4", 32'h0000_5000, 32'h0000_6000, 24'd3, 2'd1, 2'd3, 2'd2, 0, 0, 0, 0, 0, 0);
        run_job("R3", 32'h0000_7000, 32'h0000_8000, 24'd3, 2'd3, 2'd1, 2'd1, 0, 0, 0, 1, 0, 0);
        run_job("R8", 32'h0000_9000, 32'h0000_A000, 24'd9, 2'd1, 2'd1, 2'd1, 0, 1, 0, 1, 0, 0);
        run_job("R9", 32'h0000_B000, 32'h0000_C000, 24'd4, 2'd0, 2'd1, 2'd1, 0, 0, 1, 1, 0, 0);
        run_job("R2", 32'h0000_D000, 32'h0000_E000, 24'd5, 2'd1, 2'd1, 2'd1, 1, 0, 0, 1, 0, 0);
        run_job("R9", 32'h0001_0000, 32'h0002_0000, 24'd3, 2'd2, 2'd1, 2'd1, 1, 0, 1, 1, 0, 0);
        run_job("R11", 32'h0003_0000, 32'h0004_0000, 24'd6, 2'd2, 2'd1, 2'd1, 0, 0, 0, 1, 1, 0);
        run_job("R7", 32'h0005_0000, 32'h0006_0000, 24'd2, 2'd0, 2'd1, 2'd1, 0, 0, 0, 1, 0, 1);
        run_job("R7", 32'h0007_0000, 32'h0008_0000, 24'd3, 2'd1, 2'd1, 2'd1, 1, 0, 0, 1, 0, 1);

        // Constrained random jobs
        for (int i = 0; i < 24; i++) begin
            sg = 1'($urandom % 2); rl = 1'($urandom % 2); ind = 1'($urandom % 2);
            if (ind && !sg) tg = "R9";
            else if (rl) tg = "R8";
            else if (sg) tg = "R2";
            else tg = "R4";
            run_job(tg, $urandom, $urandom, 24'(1 + $urandom % 9), 2'($urandom % 3),
                    2'($urandom % 4), 2'($urandom % 4), sg, rl, ind, 1'($urandom % 2), 0,
                    1'($urandom % 2));
        end

        // Count of zero means 2^24 transfers: first transfer leaves all ones
        launch("R5", 32'h0009_0000, 32'h000A_0000, 24'd0, 2'd2, 2'd1, 2'd1, 0, 0, 0, 1, 0);
        while (xfer_left != 24'hFFFFFF) @(negedge clk);
        chk(busy == 1'b1, "R5", 32'(busy), 32'd1);
        chk(done_flag == 1'b0, "R5", 32'(done_flag), 32'd0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();

        summary();
    end

endmodule